// File: doc/BRIEF.md
# Receive Buffer Status Word Generator

This block produces the status word that the receive path writes back into each host buffer descriptor while an incoming frame is spread over one or more buffers. The receive MAC feeds it strobes marking the start of a frame, a switch to a fresh buffer, the end of the frame and a FIFO overrun. At the end of the frame it also supplies the frame attributes: a trailing partial byte (dribble), a bad frame check sequence, and the results of the physical, hash and broadcast address filters. A PHY receive-error level may arrive at any time during the frame. The loopback and look-ahead mode bits and a broadcast-to-hash control bit alter how the flags are formed.

A three-state machine controls the frame. `S_IDLE` waits for a start strobe. `S_FIRST` means a frame is open and no buffer has been written yet. `S_CHAIN` means a frame is open and at least one buffer has been written. The named transitions are:
- START: any state goes to `S_FIRST` on a start strobe.
- SWITCH: `S_FIRST` or `S_CHAIN` goes to `S_CHAIN` on a buffer switch.
- FINISH: `S_FIRST` or `S_CHAIN` goes to `S_IDLE` on end of frame.
- ABORT: `S_FIRST` or `S_CHAIN` goes to `S_IDLE` on overflow.

Each SWITCH, FINISH or ABORT produces one write-back strobe. The status word for that buffer appears with it on the next cycle.

Top module: `rx_desc_status`

## Requirements
- R1: `wb_valid_o` is high for exactly the one cycle after a clock edge that sees a buffer switch, end or overflow strobe while a frame is open. Strobes seen while no frame is open produce no write-back.
- R2: The status word fields are err[8], fram[7], oflo[6], crc[5], stp[4], enp[3], pam[2], lafm[1] and bam[0]. stp is set only in the first write-back of a frame and enp only in the end-of-frame write-back, so a one-buffer frame carries both flags and a middle buffer carries neither.
- R3: While `lookahead_i` is high, stp is written as 0.
- R4: fram is set in the end-of-frame word only when dribble and FCS error are both present and loopback is off. Dribble with a good FCS leaves fram clear.
- R5: crc is set in the end-of-frame word when the FCS error flag is present or when the PHY receive error was high in any cycle from the start strobe through the end strobe. The start strobe clears this memory.
- R6: In every word with enp clear, fram and crc are 0. This covers switch words and overflow words.
- R7: An overflow inside an open frame writes a word with oflo=1 and enp=0 and closes the frame. Later switch and end strobes are ignored until the next start strobe.
- R8: err equals fram OR oflo OR crc in every written word.
- R9: pam and bam copy the physical match and broadcast inputs in the end-of-frame word only, and lafm is 0 in every word with enp clear.
- R10: In the end-of-frame word, lafm is the hash match input, except that it is forced to 0 for a broadcast frame while `bcast_hash_en_i` is low.
- R11: The start strobe wins over every other strobe in the same cycle: it discards the open frame without a write-back and opens a new one. Within an open frame, overflow wins over end, and end wins over buffer switch.
- R12: After reset, `wb_valid_o` is 0 and `status_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof_i | input | 1 | Start-of-frame strobe |
| bufsw_i | input | 1 | Buffer full, moving to the next buffer |
| eof_i | input | 1 | End-of-frame strobe |
| ovf_i | input | 1 | Receive FIFO overrun strobe |
| dribble_i | input | 1 | Frame length is not a whole number of bytes (valid with eof_i) |
| fcs_err_i | input | 1 | FCS check failed (valid with eof_i) |
| phy_rxer_i | input | 1 | PHY receive-error indication, any cycle |
| loopback_i | input | 1 | Internal loopback mode |
| lookahead_i | input | 1 | Look-ahead mode, host owns the start flag |
| bcast_hash_en_i | input | 1 | Let broadcast frames also report a hash match |
| phys_match_i | input | 1 | Physical address filter hit (valid with eof_i) |
| hash_match_i | input | 1 | Hash filter hit (valid with eof_i) |
| bcast_i | input | 1 | Broadcast destination (valid with eof_i) |
| wb_valid_o | output | 1 | Write-back strobe |
| status_o | output | 9 | Status word for the buffer being written |

## Verification
The bench targets the cases where a flag leaks into the wrong descriptor. If crc or fram were set on a middle buffer or an overflow word, the host would see errors on frames that never ended. If a receive error pulsed mid-frame were lost, or were carried into the next frame, crc would be missing or spurious at the end. Overflow followed by a stray end strobe must produce no second write-back. A design that got this wrong would report the same frame twice. The bench also exercises broadcast frames with the hash control bit in both states, loopback with dribble plus a bad FCS, look-ahead mode, and strobes that arrive together. A wrong precedence among them would show up as a wrong flag or a missing write-back.

// File: rtl/rxst_pkg.sv
package rxst_pkg;

    localparam int ST_W = 9;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FIRST = 2'd1,
        S_CHAIN = 2'd2
    } rx_state_t;

    typedef enum logic [1:0] {
        EV_NONE   = 2'd0,
        EV_SWITCH = 2'd1,
        EV_END    = 2'd2,
        EV_OVF    = 2'd3
    } wb_kind_t;

    typedef struct packed {
        logic err;
        logic fram;
        logic oflo;
        logic crc;
        logic stp;
        logic enp;
        logic pam;
        logic lafm;
        logic bam;
    } rx_status_t;

endpackage

// File: rtl/rxst_fsm.sv
module rxst_fsm
    import rxst_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sof,
    input  logic      bufsw,
    input  logic      eof,
    input  logic      ovf,
    output rx_state_t state,
    output wb_kind_t  kind
);

    rx_state_t nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt  = state;
        kind = EV_NONE;
        if (sof) begin
            nxt = S_FIRST;                     // START
        end else begin
            unique case (state)
                S_IDLE: nxt = S_IDLE;
                S_FIRST, S_CHAIN: begin
                    if (ovf) begin
                        kind = EV_OVF;         // ABORT
                        nxt  = S_IDLE;
                    end else if (eof) begin
                        kind = EV_END;         // FINISH
                        nxt  = S_IDLE;
                    end else if (bufsw) begin
                        kind = EV_SWITCH;      // SWITCH
                        nxt  = S_CHAIN;
                    end
                end
                default: nxt = S_IDLE;
            endcase
        end
    end

    AST_SOF_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> state == S_FIRST);                                  // R11
    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !sof) |=> state == S_IDLE);             // R7

endmodule

// File: rtl/rxst_rxer_acc.sv
module rxst_rxer_acc (
    input  logic clk,
    input  logic rst_n,
    input  logic sof,
    input  logic in_frame,
    input  logic phy_rxer,
    output logic rxer_seen
);

    logic seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                    seen_q <= 1'b0;
        else if (sof)                  seen_q <= phy_rxer;
        else if (in_frame && phy_rxer) seen_q <= 1'b1;
    end

    assign rxer_seen = seen_q | phy_rxer;

    AST_ACC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !sof) |=> seen_q);                               // R5

endmodule

// File: rtl/rxst_word.sv
module rxst_word
    import rxst_pkg::*;
(
    input  wb_kind_t   kind,
    input  logic       first,
    input  logic       lookahead,
    input  logic       loopback,
    input  logic       bcast_hash_en,
    input  logic       dribble,
    input  logic       fcs_err,
    input  logic       rxer_seen,
    input  logic       phys_match,
    input  logic       hash_match,
    input  logic       bcast,
    output rx_status_t word
);

    always_comb begin
        word = '0;
        if (kind != EV_NONE) begin
            word.stp  = first & ~lookahead;
            word.enp  = (kind == EV_END);
            word.oflo = (kind == EV_OVF);
            if (kind == EV_END) begin
                word.crc  = fcs_err | rxer_seen;
                word.fram = dribble & fcs_err & ~loopback;
                word.pam  = phys_match;
                word.bam  = bcast;
                word.lafm = hash_match & (~bcast | bcast_hash_en);
            end
            word.err = word.fram | word.oflo | word.crc;
        end
    end

endmodule

// File: rtl/rx_desc_status.sv
module rx_desc_status
    import rxst_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sof_i,
    input  logic            bufsw_i,
    input  logic            eof_i,
    input  logic            ovf_i,
    input  logic            dribble_i,
    input  logic            fcs_err_i,
    input  logic            phy_rxer_i,
    input  logic            loopback_i,
    input  logic            lookahead_i,
    input  logic            bcast_hash_en_i,
    input  logic            phys_match_i,
    input  logic            hash_match_i,
    input  logic            bcast_i,
    output logic            wb_valid_o,
    output logic [ST_W-1:0] status_o
);

    rx_state_t  state;
    wb_kind_t   kind;
    logic       rxer_seen;
    rx_status_t word;
    rx_status_t st_q;

    rxst_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .sof   (sof_i),
        .bufsw (bufsw_i),
        .eof   (eof_i),
        .ovf   (ovf_i),
        .state (state),
        .kind  (kind)
    );

    rxst_rxer_acc u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .sof       (sof_i),
        .in_frame  (state != S_IDLE),
        .phy_rxer  (phy_rxer_i),
        .rxer_seen (rxer_seen)
    );

    rxst_word u_word (
        .kind          (kind),
        .first         (state == S_FIRST),
        .lookahead     (lookahead_i),
        .loopback      (loopback_i),
        .bcast_hash_en (bcast_hash_en_i),
        .dribble       (dribble_i),
        .fcs_err       (fcs_err_i),
        .rxer_seen     (rxer_seen),
        .phys_match    (phys_match_i),
        .hash_match    (hash_match_i),
        .bcast         (bcast_i),
        .word          (word)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid_o <= 1'b0;
            st_q       <= '0;
        end else begin
            wb_valid_o <= (kind != EV_NONE);
            st_q       <= word;
        end
    end

    assign status_o = st_q;

    AST_WB_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid_o |-> $past(state != S_IDLE));                                   // R1
    AST_OFLO_NO_END: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid_o && st_q.oflo) |-> (!st_q.enp && !st_q.fram && !st_q.crc));   // R7
    AST_MIDBUF_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid_o && !st_q.enp) |-> (!st_q.fram && !st_q.crc));                // R6
    AST_MATCH_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid_o && !st_q.enp) |-> (!st_q.pam && !st_q.lafm && !st_q.bam));   // R9
    AST_ERR_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid_o |-> (st_q.err == (st_q.fram | st_q.oflo | st_q.crc)));         // R8
    AST_LOOPBACK_NO_FRAM: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid_o && $past(loopback_i)) |-> !st_q.fram);                        // R4
    AST_LOOKAHEAD_NO_STP: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid_o && $past(lookahead_i)) |-> !st_q.stp);                        // R3
    AST_QUIET_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_valid_o |-> (status_o == '0));                                        // R12

endmodule

// File: tb/sim_rx_desc_status.sv
module sim_rx_desc_status;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sof = 0, bufsw = 0, eof = 0, ovf = 0, dribble = 0, fcs = 0, rxer = 0;
    logic loopback = 0, lookahead = 0, bhen = 0, phys = 0, hash = 0, bcast = 0;
    logic       wb;
    logic [8:0] st;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rx_desc_status u0 (
        .clk(clk), .rst_n(rst_n), .sof_i(sof), .bufsw_i(bufsw), .eof_i(eof),
        .ovf_i(ovf), .dribble_i(dribble), .fcs_err_i(fcs), .phy_rxer_i(rxer),
        .loopback_i(loopback), .lookahead_i(lookahead), .bcast_hash_en_i(bhen),
        .phys_match_i(phys), .hash_match_i(hash), .bcast_i(bcast),
        .wb_valid_o(wb), .status_o(st)
    );

    // Behavioural reference, updated on every rising edge
    bit       m_open, m_first, m_rx;
    bit       exp_wb;
    bit [8:0] exp_st;

    function automatic bit [8:0] mk(bit e, bit fr, bit o, bit c, bit s, bit n, bit p, bit l, bit b);
        return {e, fr, o, c, s, n, p, l, b};
    endfunction

    always @(posedge clk) begin
        bit rxnow, c, fr, lf;
        if (!rst_n) begin
            m_open = 0; m_first = 0; m_rx = 0; exp_wb = 0; exp_st = '0;
        end else begin
            exp_wb = 0; exp_st = '0;
            if (sof) begin
                m_open = 1; m_first = 1; m_rx = rxer;
            end else if (m_open) begin
                rxnow = m_rx | rxer;
                if (ovf) begin
                    exp_wb = 1;
                    exp_st = mk(1, 0, 1, 0, m_first && !lookahead, 0, 0, 0, 0);
                    m_open = 0;
                end else if (eof) begin
                    c  = fcs || rxnow;
                    fr = dribble && fcs && !loopback;
                    lf = hash && (!bcast || bhen);
                    exp_wb = 1;
                    exp_st = mk(c || fr, fr, 0, c, m_first && !lookahead, 1, phys, lf, bcast);
                    m_open = 0;
                end else if (bufsw) begin
                    exp_wb = 1;
                    exp_st = mk(0, 0, 0, 0, m_first && !lookahead, 0, 0, 0, 0);
                    m_first = 0;
                end
                m_rx = rxnow;
            end
        end
    end

    // Per-cycle comparison against the reference
    string bitreq [9] = '{"R9", "R10", "R9", "R2", "R2", "R5", "R7", "R4", "R8"};
    string bitname[9] = '{"bam", "lafm", "pam", "enp", "stp", "crc", "oflo", "fram", "err"};
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (wb !== exp_wb) begin
                failures++;
                $display("FAIL R1 wb_valid actual=%b expected=%b t=%0t", wb, exp_wb, $time);
            end
            for (int i = 0; i < 9; i++) begin
                if (st[i] !== exp_st[i]) begin
                    failures++;
                    $display("FAIL %s %s actual=%b expected=%b t=%0t",
                             bitreq[i], bitname[i], st[i], exp_st[i], $time);
                end
            end
        end
    end

    task automatic tick();
        @(negedge clk);
        sof = 0; bufsw = 0; eof = 0; ovf = 0; dribble = 0; fcs = 0; rxer = 0;
        phys = 0; hash = 0; bcast = 0;
    endtask

    task automatic expect_wb(string tag, bit w, bit [8:0] word);
        checks++;
        if (wb !== w || st !== word) begin
            failures++;
            $display("FAIL %s actual wb=%b st=%b expected wb=%b st=%b", tag, wb, st, w, word);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        expect_wb("R12 reset", 0, '0);
        rst_n = 1;
        tick();

        // R1: strobes with no open frame
        bufsw = 1; tick(); expect_wb("R1 idle switch", 0, '0);
        eof = 1;   tick(); expect_wb("R1 idle end", 0, '0);
        ovf = 1;   tick(); expect_wb("R1 idle ovf", 0, '0);

        // R2/R9: one-buffer frame with physical hit
        sof = 1; tick();
        eof = 1; phys = 1; tick(); expect_wb("R2 single buffer", 1, mk(0,0,0,0,1,1,1,0,0));

        // R2/R6/R4: three buffers, bad fcs with dribble
        sof = 1; tick();
        bufsw = 1; tick(); expect_wb("R2 first of chain", 1, mk(0,0,0,0,1,0,0,0,0));
        bufsw = 1; tick(); expect_wb("R6 middle buffer", 1, '0);
        eof = 1; fcs = 1; dribble = 1; tick(); expect_wb("R4 fram end", 1, mk(1,1,0,1,0,1,0,0,0));

        // R4: dribble with good fcs
        sof = 1; tick();
        eof = 1; dribble = 1; tick(); expect_wb("R4 dribble good fcs", 1, mk(0,0,0,0,1,1,0,0,0));

        // R4: loopback hides fram
        loopback = 1;
        sof = 1; tick();
        eof = 1; dribble = 1; fcs = 1; tick(); expect_wb("R4 loopback", 1, mk(1,0,0,1,1,1,0,0,0));
        loopback = 0;

        // R5/R6: receive error mid-frame
        sof = 1; tick();
        rxer = 1; tick();
        bufsw = 1; tick(); expect_wb("R6 switch after rxer", 1, mk(0,0,0,0,1,0,0,0,0));
        tick();
        eof = 1; tick(); expect_wb("R5 rxer remembered", 1, mk(1,0,0,1,0,1,0,0,0));
        sof = 1; tick();
        eof = 1; tick(); expect_wb("R5 cleared at start", 1, mk(0,0,0,0,1,1,0,0,0));

        // R7: overflow after a switch, then stray end
        sof = 1; tick();
        bufsw = 1; tick();
        ovf = 1; fcs = 1; tick(); expect_wb("R7 overflow word", 1, mk(1,0,1,0,0,0,0,0,0));
        eof = 1; tick(); expect_wb("R7 end ignored", 0, '0);
        bufsw = 1; tick(); expect_wb("R7 switch ignored", 0, '0);

        // R10: broadcast and hash precedence
        sof = 1; tick();
        eof = 1; bcast = 1; hash = 1; tick(); expect_wb("R10 bcast hash off", 1, mk(0,0,0,0,1,1,0,0,1));
        bhen = 1;
        sof = 1; tick();
        eof = 1; bcast = 1; hash = 1; tick(); expect_wb("R10 bcast hash on", 1, mk(0,0,0,0,1,1,0,1,1));
        bhen = 0;
        sof = 1; tick();
        eof = 1; hash = 1; tick(); expect_wb("R10 unicast hash", 1, mk(0,0,0,0,1,1,0,1,0));

        // R3: look-ahead
        lookahead = 1;
        sof = 1; tick();
        eof = 1; tick(); expect_wb("R3 lookahead", 1, mk(0,0,0,0,0,1,0,0,0));
        lookahead = 0;

        // R11: precedence of simultaneous strobes
        sof = 1; tick();
        eof = 1; ovf = 1; tick(); expect_wb("R11 ovf over end", 1, mk(1,0,1,0,1,0,0,0,0));
        sof = 1; tick();
        bufsw = 1; tick();
        sof = 1; eof = 1; tick(); expect_wb("R11 start over end", 0, '0);
        eof = 1; tick(); expect_wb("R11 restarted frame", 1, mk(0,0,0,0,1,1,0,0,0));
        sof = 1; tick();
        bufsw = 1; eof = 1; tick(); expect_wb("R11 end over switch", 1, mk(0,0,0,0,1,1,0,0,0));

        tick();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule